// File: doc/BRIEF.md
# Two-Event Timing Relation Monitor

This block watches two single-bit event strobes, called A and B, and checks one timing relation between them at run time. The relation is fixed at elaboration. It can be one of four kinds: coincidence, ordering, bounded response, or minimum separation. An activation pulse opens a fresh check instance. Within an instance, only the first cycle in which each strobe is high counts as that strobe's event. Pulses after the first are ignored, as are pulses while no instance is open.

Each instance ends in one of two ways. It is satisfied, or it is broken. A broken relation raises one of two sticky flags, chosen by the severity parameter. A hard relation raises the error flag. A soft relation is an assumption on the environment, so breaking it raises the preempt flag, and that flag drops every remaining obligation of the instance. An unbounded response relation can never fail. While the response is outstanding it shows a pending flag instead.

The controller is a Moore state machine with these states:
- IDLE: no instance is open.
- WAIT: no event has been seen yet.
- GOT_A: A came first and a window is running.
- GOT_B: B came first and a window is running.
- MET: the relation is satisfied.
- FAULT: a hard relation was broken.
- PREEMPT: a soft relation was broken.

The transitions are:
- *reset*: any state to IDLE.
- *arm*: any state to WAIT on activation.
- *open_a* and *open_b*: WAIT to GOT_A or GOT_B on a first event.
- *settle*: WAIT, GOT_A or GOT_B to MET.
- *break*: WAIT, GOT_A or GOT_B to FAULT or PREEMPT.

A cycle counter counts clock transitions from the first event. It supplies the window limit.

Top module: `evt_relation_monitor`

## Requirements
- R1: After reset, and until the first activation, err_o, preempt_o and pending_o are 0, whatever the strobes do.
- R2: When start_i is high at a clock edge, all three flags read 0 after that edge. The strobes in the start cycle are ignored. Only the first high cycle of each strobe after the start cycle counts; later pulses are ignored.
- R3: Coincidence (REL = REL_SIMUL): if the first events of A and B fall in different cycles, the relation is broken in the cycle of the earlier one. If they fall in the same cycle, it is satisfied.
- R4: Ordering (REL = REL_PREC): a first B in a cycle with no earlier or simultaneous A breaks the relation in that cycle. A first A satisfies it, and any later B is then free.
- R5: Bounded response (REL = REL_LEADS, UNBOUNDED = 0): let A be at cycle c. A B at or before c, or one at c+d with d < T_BOUND, satisfies the relation. Otherwise the relation breaks in cycle c+T_BOUND-1.
- R6: Unbounded response (UNBOUNDED = 1): the relation never breaks. pending_o is 1 from the cycle after the first A until the cycle after the first B. It stays 0 if B came first.
- R7: Separation (REL = REL_CONFLICT, T_BOUND ≥ 1): the relation breaks when both first events exist and their distance in cycles is less than T_BOUND. The break happens in the cycle of the later one.
- R8: With WEAK = 0, a break raises err_o in the cycle after it is detected. err_o then stays 1 until the next activation or reset.
- R9: With WEAK = 1, a break raises preempt_o instead, one cycle after detection. preempt_o stays 1 until the next activation or reset, and no further flag changes in that instance.
- R10: err_o and preempt_o are never 1 together. A soft break resolves to preempt only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one counted transition per rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Activation pulse; opens a new check instance |
| ev_a_i | input | 1 | Event strobe A |
| ev_b_i | input | 1 | Event strobe B |
| err_o | output | 1 | Sticky hard-relation violation |
| preempt_o | output | 1 | Sticky soft-relation violation; checking silenced |
| pending_o | output | 1 | Unbounded response outstanding |

## Verification
The bench builds five copies of the block side by side and drives all of them with the same stimulus:

| Copy | Relation | Severity | T_BOUND |
|---|---|---|---|
| 1 | Hard bounded response | hard | 3 |
| 2 | Hard coincidence | hard | – |
| 3 | Soft ordering | soft | – |
| 4 | Soft separation | soft | 3 |
| 5 | Unbounded response | – | – |

A bound of three makes it possible to place a B one short of, exactly at, and past the response window. The same bound puts separation distances on both sides of the limit.

Running every variant on one event pattern shows the same stimulus satisfying one relation while breaking another. It also exercises the error and preempt paths, the pending flag, and restarts that clear sticky flags.

// File: rtl/evt_mon_pkg.sv
package evt_mon_pkg;

    typedef enum logic [1:0] {
        REL_SIMUL    = 2'd0,
        REL_PREC     = 2'd1,
        REL_LEADS    = 2'd2,
        REL_CONFLICT = 2'd3
    } rel_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_WAIT    = 3'd1,
        ST_GOT_A   = 3'd2,
        ST_GOT_B   = 3'd3,
        ST_MET     = 3'd4,
        ST_FAULT   = 3'd5,
        ST_PREEMPT = 3'd6
    } mon_state_e;

endpackage

// File: rtl/evt_age_counter.sv
module evt_age_counter #(
    parameter int T_BOUND = 4,
    parameter int CW      = $clog2(T_BOUND + 1)
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clr_i,
    input  logic run_i,
    output logic at_lim_o
);

    localparam logic [CW-1:0] LIM = CW'(T_BOUND - 1);
    localparam logic [CW-1:0] TOP = '1;

    logic [CW-1:0] age_q;

    // The count holds 1 in the first cycle after an event: it is that cycle's distance from the event.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            age_q <= '0;
        end else if (clr_i) begin
            age_q <= CW'(1);
        end else if (run_i && age_q != TOP) begin
            age_q <= age_q + CW'(1);
        end
    end

    assign at_lim_o = (age_q == LIM);

endmodule

// File: rtl/evt_rel_decide.sv
module evt_rel_decide
    import evt_mon_pkg::*;
#(
    parameter rel_kind_e REL       = REL_LEADS,
    parameter bit        WEAK      = 1'b0,
    parameter int        T_BOUND   = 4,
    parameter bit        UNBOUNDED = 1'b0
) (
    input  mon_state_e state_i,
    input  logic       ev_a_i,
    input  logic       ev_b_i,
    input  logic       at_lim_i,
    output mon_state_e nxt_o
);

    localparam mon_state_e BAD  = WEAK ? ST_PREEMPT : ST_FAULT;
    localparam bit         T_ONE = (T_BOUND == 1);

    generate
        if (REL == REL_SIMUL) begin : g_simul
            always_comb begin
                nxt_o = state_i;
                unique case (state_i)
                    ST_WAIT: begin
                        if (ev_a_i && ev_b_i)      nxt_o = ST_MET;
                        else if (ev_a_i || ev_b_i) nxt_o = BAD;
                    end
                    ST_GOT_A, ST_GOT_B: if (at_lim_i) nxt_o = ST_MET;
                    default: nxt_o = state_i;
                endcase
            end
        end else if (REL == REL_PREC) begin : g_prec
            always_comb begin
                nxt_o = state_i;
                unique case (state_i)
                    ST_WAIT: begin
                        if (ev_b_i && !ev_a_i) nxt_o = BAD;
                        else if (ev_a_i)       nxt_o = ST_MET;
                    end
                    ST_GOT_A, ST_GOT_B: if (at_lim_i) nxt_o = ST_MET;
                    default: nxt_o = state_i;
                endcase
            end
        end else if (REL == REL_LEADS) begin : g_leads
            always_comb begin
                nxt_o = state_i;
                unique case (state_i)
                    ST_WAIT: begin
                        if (ev_b_i)      nxt_o = ST_MET;
                        else if (ev_a_i) nxt_o = (T_ONE && !UNBOUNDED) ? BAD : ST_GOT_A;
                    end
                    ST_GOT_A: begin
                        if (ev_b_i)                       nxt_o = ST_MET;
                        else if (at_lim_i && !UNBOUNDED)  nxt_o = BAD;
                    end
                    ST_GOT_B: if (at_lim_i) nxt_o = ST_MET;
                    default: nxt_o = state_i;
                endcase
            end
        end else begin : g_conflict
            always_comb begin
                nxt_o = state_i;
                unique case (state_i)
                    ST_WAIT: begin
                        if (ev_a_i && ev_b_i) nxt_o = BAD;
                        else if (ev_a_i)      nxt_o = T_ONE ? ST_MET : ST_GOT_A;
                        else if (ev_b_i)      nxt_o = T_ONE ? ST_MET : ST_GOT_B;
                    end
                    ST_GOT_A: begin
                        if (ev_b_i)        nxt_o = BAD;
                        else if (at_lim_i) nxt_o = ST_MET;
                    end
                    ST_GOT_B: begin
                        if (ev_a_i)        nxt_o = BAD;
                        else if (at_lim_i) nxt_o = ST_MET;
                    end
                    default: nxt_o = state_i;
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/evt_relation_monitor.sv
module evt_relation_monitor
    import evt_mon_pkg::*;
#(
    parameter rel_kind_e REL       = REL_LEADS,
    parameter bit        WEAK      = 1'b0,
    parameter int        T_BOUND   = 4,
    parameter bit        UNBOUNDED = 1'b0
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    input  logic ev_a_i,
    input  logic ev_b_i,
    output logic err_o,
    output logic preempt_o,
    output logic pending_o
);

    localparam int  CW       = $clog2(T_BOUND + 1);
    localparam bit  HAS_PEND = (REL == REL_LEADS) && UNBOUNDED;

    mon_state_e state_q, state_nxt;
    logic       in_window, at_lim;

    assign in_window = (state_q == ST_GOT_A) || (state_q == ST_GOT_B);

    evt_age_counter #(
        .T_BOUND (T_BOUND),
        .CW      (CW)
    ) age_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .clr_i    (!in_window),
        .run_i    (in_window),
        .at_lim_o (at_lim)
    );

    evt_rel_decide #(
        .REL       (REL),
        .WEAK      (WEAK),
        .T_BOUND   (T_BOUND),
        .UNBOUNDED (UNBOUNDED)
    ) decide_i (
        .state_i  (state_q),
        .ev_a_i   (ev_a_i),
        .ev_b_i   (ev_b_i),
        .at_lim_i (at_lim),
        .nxt_o    (state_nxt)
    );

    // State register: activation overrides every other transition.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else if (start_i) begin
            state_q <= ST_WAIT;
        end else begin
            state_q <= state_nxt;
        end
    end

    // Moore outputs.
    always_comb begin
        err_o     = 1'b0;
        preempt_o = 1'b0;
        pending_o = 1'b0;
        unique case (state_q)
            ST_FAULT:   err_o     = 1'b1;
            ST_PREEMPT: preempt_o = 1'b1;
            ST_GOT_A:   pending_o = HAS_PEND;
            default:    ;
        endcase
    end

endmodule

// File: rtl/evt_relation_monitor_chk.sv
module evt_relation_monitor_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic start_i,
    input logic ev_b_i,
    input logic err_o,
    input logic preempt_o,
    input logic pending_o
);

    // R10
    excl_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(err_o && preempt_o));

    // R8
    err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (err_o && !start_i) |=> err_o);

    // R9
    pre_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (preempt_o && !start_i) |=> (preempt_o && !pending_o));

    // R2
    start_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> (!err_o && !preempt_o && !pending_o));

    // R6
    pend_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pending_o && ev_b_i && !start_i) |=> !pending_o);

endmodule

bind evt_relation_monitor evt_relation_monitor_chk chk_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .ev_b_i    (ev_b_i),
    .err_o     (err_o),
    .preempt_o (preempt_o),
    .pending_o (pending_o)
);

// File: tb/evt_relation_monitor_tb_top.sv
module evt_relation_monitor_tb_top;
    import evt_mon_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NDUT       = 5;
    localparam int TB         = 3;
    // relation codes: 0 coincidence, 1 ordering, 2 response, 3 separation
    localparam int REL_C [NDUT] = '{2, 0, 1, 3, 2};
    localparam int WEAK_C[NDUT] = '{0, 0, 1, 1, 0};
    localparam int UNB_C [NDUT] = '{0, 0, 0, 0, 1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic st = 1'b0, ea = 1'b0, eb = 1'b0;
    logic [NDUT-1:0] err, pre, pend;

    int checks = 0;
    int fails  = 0;
    bit active = 0;
    int te = -1, tf = -1, n = -1;

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_relation_monitor #(.REL(REL_LEADS), .WEAK(1'b0), .T_BOUND(TB), .UNBOUNDED(1'b0)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .start_i(st), .ev_a_i(ea), .ev_b_i(eb),
        .err_o(err[0]), .preempt_o(pre[0]), .pending_o(pend[0]));
    evt_relation_monitor #(.REL(REL_SIMUL), .WEAK(1'b0), .T_BOUND(TB), .UNBOUNDED(1'b0)) dut_sim (
        .clk_i(clk), .rst_ni(rst_n), .start_i(st), .ev_a_i(ea), .ev_b_i(eb),
        .err_o(err[1]), .preempt_o(pre[1]), .pending_o(pend[1]));
    evt_relation_monitor #(.REL(REL_PREC), .WEAK(1'b1), .T_BOUND(TB), .UNBOUNDED(1'b0)) dut_prec (
        .clk_i(clk), .rst_ni(rst_n), .start_i(st), .ev_a_i(ea), .ev_b_i(eb),
        .err_o(err[2]), .preempt_o(pre[2]), .pending_o(pend[2]));
    evt_relation_monitor #(.REL(REL_CONFLICT), .WEAK(1'b1), .T_BOUND(TB), .UNBOUNDED(1'b0)) dut_conf (
        .clk_i(clk), .rst_ni(rst_n), .start_i(st), .ev_a_i(ea), .ev_b_i(eb),
        .err_o(err[3]), .preempt_o(pre[3]), .pending_o(pend[3]));
    evt_relation_monitor #(.REL(REL_LEADS), .WEAK(1'b0), .T_BOUND(TB), .UNBOUNDED(1'b1)) dut_unb (
        .clk_i(clk), .rst_ni(rst_n), .start_i(st), .ev_a_i(ea), .ev_b_i(eb),
        .err_o(err[4]), .preempt_o(pre[4]), .pending_o(pend[4]));

    // Behavioural verdict: is the relation broken given first-event times up to cycle n?
    function automatic bit broken(int rel, int unb);
        case (rel)
            0: return (te >= 0 || tf >= 0) && (te != tf);                       // R3
            1: return (tf >= 0) && (te < 0 || tf < te);                         // R4
            2: return (unb == 0) && (te >= 0) && (n >= te + TB - 1)
                      && (tf < 0 || tf > te + TB - 1);                          // R5
            default: return (te >= 0) && (tf >= 0)
                      && (((te > tf) ? te - tf : tf - te) < TB);                // R7
        endcase
    endfunction

    function automatic string tag(int k);
        if (!active) return "R1";
        if (n < 0)   return "R2";
        case (REL_C[k])
            0: return "R3";
            1: return "R4";
            2: return (UNB_C[k] != 0) ? "R6" : "R5";
            default: return "R7";
        endcase
    endfunction

    task automatic compare_all();
        for (int k = 0; k < NDUT; k++) begin
            bit v, x_err, x_pre, x_pend;
            v      = active && broken(REL_C[k], UNB_C[k]);
            x_err  = v && (WEAK_C[k] == 0);                                     // R8
            x_pre  = v && (WEAK_C[k] != 0);                                     // R9
            x_pend = active && (UNB_C[k] != 0) && (te >= 0) && (tf < 0);        // R6
            checks++;
            if ({err[k], pre[k], pend[k]} !== {x_err, x_pre, x_pend}) begin
                fails++;
                $display("FAIL %s/%s dut%0d n=%0d: err/pre/pend actual=%b%b%b expected=%b%b%b",
                         tag(k), (WEAK_C[k] != 0) ? "R9" : "R8", k, n,
                         err[k], pre[k], pend[k], x_err, x_pre, x_pend);
            end
            checks++;
            if (err[k] && pre[k]) begin
                fails++;
                $display("FAIL R10 dut%0d: err=1 pre=1 actual, expected not both", k);
            end
        end
    endtask

    // One cycle: drive at negedge, let the edge pass, update the model, compare at the next negedge.
    task automatic step(input logic s, input logic a, input logic b);
        st = s; ea = a; eb = b;
        @(posedge clk);
        if (s) begin
            active = 1; te = -1; tf = -1; n = -1;
        end else if (active) begin
            n++;
            if (a && te < 0) te = n;
            if (b && tf < 0) tf = n;
        end
        @(negedge clk);
        compare_all();
    endtask

    task automatic run_case(input logic [15:0] a_bits, input logic [15:0] b_bits,
                            input int len, input logic start_ev);
        step(1'b1, start_ev, start_ev);
        for (int i = 0; i < len; i++) step(1'b0, a_bits[i], b_bits[i]);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        // R1: strobes before any activation are ignored
        step(1'b0, 1'b1, 1'b0);
        step(1'b0, 1'b0, 1'b1);
        step(1'b0, 1'b1, 1'b1);
        run_case(16'b00001, 16'b00100, 6, 1'b0);    // A@0 B@2
        run_case(16'b00001, 16'b00000, 6, 1'b0);    // A only: R5 break, R6 pending held
        run_case(16'b01000, 16'b00010, 6, 1'b0);    // B before A: R4 preempt
        run_case(16'b00010, 16'b00010, 5, 1'b0);    // joint: R3 met, R7 break
        run_case(16'b00001, 16'b01000, 6, 1'b0);    // B one past window
        run_case(16'b10101, 16'b00000, 6, 1'b1);    // R2: start-cycle events and repeats ignored
        run_case(16'b001000, 16'b100000, 8, 1'b0);  // A@3 B@5
        run_case(16'b00100, 16'b00001, 6, 1'b0);    // B@0 A@2
        run_case(16'b00001, 16'b01000, 4, 1'b0);    // separation exactly TB
        run_case(16'b00000, 16'b00000, 4, 1'b0);    // no events
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule